// File: doc/BRIEF.md
# Deep Color Pixel Unpacker

This block sits behind the link decoder of a display receiver. When the link carries deep-color video, the transmitter packs several pixels into a fixed group of link characters. This block rebuilds full-width pixels from those characters. Each link character brings one 8-bit word on each of three colour channels. The block reassembles pixels from these words and emits one pixel per valid strobe, in the link clock domain. It needs no control while it runs. The only inputs it takes are the depth setting and a marker on the first character of each active line.

Each channel is treated as a little-endian bit stream. The words of a group are concatenated so that the first character occupies the lowest bits. Pixels are then cut from the bottom of this stream, `W` bits at a time, where `W` is 8, 10 or 12. Every output component is 12 bits wide and left-aligned, with zero fill below. Because pixels come out of a stream that is filled at 8 bits per character, valid pulses follow a fixed pattern in each mode. In 10-bit mode the pattern repeats every 5 characters. In 12-bit mode it repeats every 3 characters.

Top module: `dcu_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pix_valid` is 0 and `pix_data` is all zero.
- R2: In 8-bit mode (`depth_sel` = 2'b00, and also 2'b11), every character produces one pixel. Each component equals the channel word followed by four zero bits.
- R3: In 10-bit mode (`depth_sel` = 2'b01), the five characters c0..c4 of a group form the 40-bit value {c4,c3,c2,c1,c0} per channel. Pixel k is bits [10k+9:10k] of that value. It is output as {pixel,2'b00}.
- R4: In 10-bit mode, the characters at phases 1, 2, 3 and 4 of a group each complete one pixel (pixels 0..3 in order). The character at phase 0 completes none.
- R5: In 12-bit mode (`depth_sel` = 2'b10), the three characters of a group form {c2,c1,c0} per channel. Pixel k is bits [12k+11:12k]. The characters at phases 1 and 2 complete pixels 0 and 1.
- R6: The three channels are unpacked independently. Channel n uses `link_word[8n+7:8n]` and drives `pix_data[12n+11:12n]`.
- R7: A cycle with `char_en` low changes no state and produces no valid. Gaps may occur anywhere inside a group.
- R8: `line_start`, sampled together with `char_en`, marks its character as phase 0 of a new group. Bits held over from an unfinished group are discarded, and no pixel is emitted from them.
- R9: The pixel completed by a character appears with `pix_valid` high in the cycle right after that character is sampled. `pix_data` holds its value until the next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link character clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 2 | 00/11 = 8-bit, 01 = 10-bit, 10 = 12-bit; held stable within a line |
| char_en | input | 1 | A link character is present on `link_word` |
| line_start | input | 1 | This character is the first of an active line |
| link_word | input | 24 | Three 8-bit channel words, channel 0 in the low byte |
| pix_valid | output | 1 | One-cycle strobe per reassembled pixel |
| pix_data | output | 36 | Three 12-bit left-aligned components, channel 0 in the low bits |

## Verification
Suppose the shared fill level or the group phase goes wrong. The valid pattern then drifts away from the 4-of-5 or 2-of-3 rhythm, and a scoreboard keyed on the exact expected cycle catches it at the first pixel that comes out misplaced. That pixel appears within one group of the fault. A wrong accumulator shift instead scrambles bits across pixel boundaries. This shows up as data mismatches in the affected channel only. A missed discard at a line start carries stale low bits into the first pixel of the next line, and that pixel then compares wrong.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

    localparam int LINK_W = 8;
    localparam int COMP_W = 12;

    typedef enum logic [1:0] {
        DEPTH_8   = 2'b00,
        DEPTH_10  = 2'b01,
        DEPTH_12  = 2'b10,
        DEPTH_8B  = 2'b11
    } depth_e;

    // Pixel width in bits for a depth setting
    function automatic logic [4:0] pix_bits(depth_e d);
        case (d)
            DEPTH_10: pix_bits = 5'd10;
            DEPTH_12: pix_bits = 5'd12;
            default:  pix_bits = 5'd8;
        endcase
    endfunction

    // Characters per packing group for a depth setting
    function automatic logic [2:0] group_len(depth_e d);
        case (d)
            DEPTH_10: group_len = 3'd5;
            DEPTH_12: group_len = 3'd3;
            default:  group_len = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/dcu_phase_track.sv
module dcu_phase_track
    import dcu_pkg::*;
#(
    parameter int CH_W   = LINK_W,
    parameter int OUT_W  = COMP_W,
    localparam int FILL_W = $clog2(OUT_W + CH_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  depth_e            depth,
    input  logic              char_en,
    input  logic              line_start,
    output logic [FILL_W-1:0] fill,
    output logic [4:0]        pix_w,
    output logic              emit
);

    logic [FILL_W-1:0] fill_q;
    logic [2:0]        phase_q;
    logic [2:0]        eff_phase;
    logic [2:0]        glen;
    logic [FILL_W-1:0] sum;
    logic              restart;

    assign restart   = char_en && line_start;
    assign glen      = group_len(depth);
    assign pix_w     = pix_bits(depth);
    assign fill      = restart ? '0 : fill_q;
    assign eff_phase = restart ? 3'd0 : phase_q;
    assign sum       = fill + FILL_W'(CH_W);
    assign emit      = char_en && (sum >= FILL_W'(pix_w));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= '0;
            phase_q <= '0;
        end else if (char_en) begin
            fill_q  <= emit ? (sum - FILL_W'(pix_w)) : sum;
            phase_q <= (eff_phase >= glen - 3'd1) ? 3'd0 : eff_phase + 3'd1;
        end
    end

    // R4/R5: the stream is exactly drained at the last character of a group
    a_r4_drained_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (char_en && eff_phase == glen - 3'd1) |=> (fill_q == '0));

    // R7: idle cycles leave the tracker untouched
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !char_en |=> ($stable(fill_q) && $stable(phase_q)));

    // R8: a line start always puts the next character at phase 1 in packed modes
    a_r8_restart_phase: assert property (@(posedge clk) disable iff (rst)
        (restart && glen > 3'd1) |=> (phase_q == 3'd1));

endmodule

// File: rtl/dcu_chan_unpack.sv
module dcu_chan_unpack
    import dcu_pkg::*;
#(
    parameter int CH_W   = LINK_W,
    parameter int OUT_W  = COMP_W,
    localparam int FILL_W = $clog2(OUT_W + CH_W + 1),
    localparam int ACC_W  = OUT_W + CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_en,
    input  logic              line_start,
    input  logic              emit,
    input  logic [FILL_W-1:0] fill,
    input  logic [4:0]        pix_w,
    input  logic [CH_W-1:0]   word,
    output logic [OUT_W-1:0]  comp
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] merged;
    logic [ACC_W-1:0] mask;
    logic [OUT_W-1:0] raw;
    logic [OUT_W-1:0] aligned;
    logic [4:0]       pad;

    assign base    = (char_en && line_start) ? '0 : acc_q;
    assign merged  = base | (ACC_W'(word) << fill);
    assign mask    = (ACC_W'(1) << pix_w) - ACC_W'(1);
    assign raw     = OUT_W'(merged & mask);
    assign pad     = 5'(OUT_W) - pix_w;
    assign aligned = raw << pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            comp  <= '0;
        end else if (char_en) begin
            acc_q <= emit ? (merged >> pix_w) : merged;
            if (emit) begin
                comp <= aligned;
            end
        end
    end

    // R7: no character, no change in held bits
    a_r7_acc_stable: assert property (@(posedge clk) disable iff (rst)
        !char_en |=> $stable(acc_q));

    // R9: output component only moves when a pixel was completed
    a_r9_comp_hold: assert property (@(posedge clk) disable iff (rst)
        !emit |=> $stable(comp));

endmodule

// File: rtl/dcu_top.sv
module dcu_top
    import dcu_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = LINK_W,
    parameter int OUT_W  = COMP_W,
    localparam int FILL_W = $clog2(OUT_W + CH_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              depth_sel,
    input  logic                    char_en,
    input  logic                    line_start,
    input  logic [NUM_CH*CH_W-1:0]  link_word,
    output logic                    pix_valid,
    output logic [NUM_CH*OUT_W-1:0] pix_data
);

    depth_e            depth;
    logic [FILL_W-1:0] fill;
    logic [4:0]        pix_w;
    logic              emit;

    assign depth = depth_e'(depth_sel);

    dcu_phase_track #(.CH_W(CH_W), .OUT_W(OUT_W)) trk_i (
        .clk        (clk),
        .rst        (rst),
        .depth      (depth),
        .char_en    (char_en),
        .line_start (line_start),
        .fill       (fill),
        .pix_w      (pix_w),
        .emit       (emit)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        dcu_chan_unpack #(.CH_W(CH_W), .OUT_W(OUT_W)) chan_i (
            .clk        (clk),
            .rst        (rst),
            .char_en    (char_en),
            .line_start (line_start),
            .emit       (emit),
            .fill       (fill),
            .pix_w      (pix_w),
            .word       (link_word[n*CH_W +: CH_W]),
            .comp       (pix_data[n*OUT_W +: OUT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) pix_valid <= 1'b0;
        else     pix_valid <= emit;
    end

    // R9: a valid strobe always follows a sampled character
    a_r9_valid_after_char: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(char_en));

    // R2: every character in 8-bit mode yields a pixel
    a_r2_every_char: assert property (@(posedge clk) disable iff (rst)
        (char_en && pix_w == 5'd8) |=> pix_valid);

    // R3: 10-bit pixels carry two zero bits at the bottom of each component
    a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
        (emit && depth == DEPTH_10) |=> (pix_data[1:0] == 2'b00 &&
            pix_data[OUT_W +: 2] == 2'b00 && pix_data[2*OUT_W +: 2] == 2'b00));

    // R8: the first character of a line never completes a packed pixel
    a_r8_no_pixel_at_start: assert property (@(posedge clk) disable iff (rst)
        (char_en && line_start && pix_w != 5'd8) |=> !pix_valid);

endmodule

// File: tb/dcu_top_tb_top.sv
module dcu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  depth_sel = 2'b00;
    logic        char_en = 1'b0;
    logic        line_start = 1'b0;
    logic [23:0] link_word = '0;
    logic        pix_valid;
    logic [35:0] pix_data;

    always #2 clk = ~clk;  // 250 MHz

    dcu_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .depth_sel  (depth_sel),
        .char_en    (char_en),
        .line_start (line_start),
        .link_word  (link_word),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data)
    );

    typedef struct {
        logic [35:0] data;
        int          stamp;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          run = 1'b0;
    int          bph = 0;
    logic [39:0] grp [3];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares each strobe with the oldest expected item
    always @(negedge clk) begin
        if (run && !rst) begin
            if (pix_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected valid", pix_data, '0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(pix_data == e.data, e.req, pix_data, e.data);
                    check(cyc == e.stamp, {e.req, " R9 timing"}, 36'(cyc), 36'(e.stamp));
                end
            end else if (sb_q.size() != 0 && sb_q[0].stamp <= cyc) begin
                check(1'b0, {sb_q[0].req, " R9 missing valid"}, 36'(cyc), 36'(sb_q[0].stamp));
                void'(sb_q.pop_front());
            end
        end
    end

    // Driver: models the packing from the requirement text and pushes expectations
    task automatic send(input logic [23:0] w, input bit ls);
        int glen;
        exp_t e;
        glen = (depth_sel == 2'b01) ? 5 : (depth_sel == 2'b10) ? 3 : 1;
        if (ls) begin
            bph = 0;
            for (int k = 0; k < 3; k++) grp[k] = '0;
        end
        for (int k = 0; k < 3; k++) grp[k][bph*8 +: 8] = w[k*8 +: 8];
        e.stamp = cyc + 1;
        e.data  = '0;
        if (depth_sel == 2'b01 && bph >= 1) begin
            for (int k = 0; k < 3; k++) e.data[k*12 +: 12] = {grp[k][(bph-1)*10 +: 10], 2'b00};
            e.req = "R3/R4 10-bit";
            sb_q.push_back(e);
        end else if (depth_sel == 2'b10 && bph >= 1) begin
            for (int k = 0; k < 3; k++) e.data[k*12 +: 12] = grp[k][(bph-1)*12 +: 12];
            e.req = "R5 12-bit";
            sb_q.push_back(e);
        end else if (depth_sel == 2'b00 || depth_sel == 2'b11) begin
            for (int k = 0; k < 3; k++) e.data[k*12 +: 12] = {w[k*8 +: 8], 4'h0};
            e.req = "R2 8-bit";
            sb_q.push_back(e);
        end
        bph = (bph + 1) % glen;
        char_en    = 1'b1;
        line_start = ls;
        link_word  = w;
        @(negedge clk);
        char_en    = 1'b0;
        line_start = 1'b0;
    endtask

    task automatic idle(input int n, input bit do_check);
        char_en = 1'b0;
        link_word = 24'hA5A5A5;  // ignored while char_en is low
        repeat (n) @(negedge clk);
        if (do_check) check(pix_valid == 1'b0, "R7 idle no valid", 36'(pix_valid), '0);
    endtask

    task automatic line(input logic [1:0] d, input int nchar, input bit gaps);
        depth_sel = d;
        for (int i = 0; i < nchar; i++) begin
            send(24'($urandom), i == 0);
            if (gaps && (i % 2 == 1)) idle(2, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0, "R1 valid in reset", 36'(pix_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check(pix_valid == 1'b0, "R1 valid after reset", 36'(pix_valid), '0);
        check(pix_data == '0, "R1 data after reset", pix_data, '0);
        run = 1'b1;

        // R2: 8-bit pass-through, both encodings
        line(2'b00, 6, 1'b0);
        send(24'hFF0080, 1'b0);
        line(2'b11, 4, 1'b0);
        idle(3, 1'b1);

        // R3 R4 R6: 10-bit full groups, distinct channel data
        depth_sel = 2'b01;
        send(24'h123456, 1'b1);
        for (int i = 1; i < 10; i++) send(24'($urandom), 1'b0);
        line(2'b01, 15, 1'b0);
        idle(3, 1'b1);

        // R7: gaps inside groups
        line(2'b01, 10, 1'b1);
        idle(3, 1'b1);

        // R5: 12-bit groups, with and without gaps
        line(2'b10, 9, 1'b0);
        line(2'b10, 6, 1'b1);
        idle(3, 1'b1);

        // R8: unfinished groups cut off by a new line
        line(2'b01, 3, 1'b0);
        line(2'b01, 7, 1'b0);
        line(2'b10, 1, 1'b0);
        line(2'b10, 4, 1'b0);
        send(24'hFFFFFF, 1'b0);
        depth_sel = 2'b01;
        send(24'h000000, 1'b1);
        send(24'h000000, 1'b0);
        idle(4, 1'b1);

        check(sb_q.size() == 0, "R9 pending pixels", 36'(sb_q.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule